// File: doc/BRIEF.md
# I2C Register Target with Persistent Pointer

This block lets an external host reach a small bank of 8-bit registers over a two-wire I2C-compatible bus. It only ever acts as a target, answers one fixed 7-bit address, and never stretches the clock. Both bus lines are brought through two-flop synchronisers. Start and stop conditions are found from data-line edges while the clock line is high. The block pulls the data line low through an output enable and never drives it high.

A write transaction uses its first data byte as the register pointer. Every later byte in that transaction goes to that same location, because the pointer never advances. The pointer is kept between transactions. A read that sends only the address byte therefore returns the location pointed to last, and it returns that location again for every byte the host acknowledges. Location 0 is a read-only status byte. Its bit 4 is a sticky brownout flag that drives an alert output. Reading the status byte lowers the alert. The flag itself clears only after control bit 0 has gone low-high-low and the status byte has then been read again.

Top module: `i2c_reg_target`

## Requirements
- R1: An address byte whose upper seven bits equal TGT_ADDR (default 0x20) is acknowledged by pulling SDA low in the ninth clock. Every other address, including the all-zero general call, leaves SDA released in that slot.
- R2: In a write transaction the first data byte loads the register pointer. Every later data byte is written to that same pointer with no increment. All data bytes are acknowledged.
- R3: A read transaction uses the stored pointer. Each byte the host acknowledges is followed by the same location again, MSB first. A NACK from the host ends the transfer.
- R4: Register map: location 0 reads {stat_i[6:4], brownout flag, stat_i[3:0]} and ignores writes. Locations 1..NUM_RW are read/write, reset to 0x00, and location k appears on cfg_o[(k-1)*8 +: 8]. Location 1 is the control register.
- R5: Locations above NUM_RW are acknowledged, read as 0x00, and ignore writes, so cfg_o stays unchanged.
- R6: brownout_i high on a clock edge sets the brownout flag (status bit 4) and alert_o from the next cycle.
- R7: Reading the status byte clears alert_o but leaves the brownout flag set unless R8 applies.
- R8: After control bit 0 has gone 0, then 1, then 0, the next status read returns the flag still set and clears it. Later reads return bit 4 as 0.
- R9: stat_rd_o pulses for exactly one cycle each time a status byte is loaded for transmission, and never for other locations.
- R10: A STOP, or a repeated START, abandons any transfer in progress. A byte cut off by either is not written, and SDA is released.
- R11: After reset, SDA is released, alert_o is low, cfg_o is zero and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | High pulls the data line low |
| stat_i | input | 7 | Live status bits placed around bit 4 of location 0 |
| brownout_i | input | 1 | Brownout event from the supply monitor |
| stat_rd_o | output | 1 | One-cycle pulse when the status byte is read |
| alert_o | output | 1 | Brownout alert to the host |
| cfg_o | output | NUM_RW*8 | Contents of the read/write registers, location 1 in the low byte |

## Verification
The bench sweeps all 128 address bytes. A decoder that compares the read/write bit, or that accepts the general call, shows up as a wrong acknowledge. Every location from 0 to 7 is written and read back. An auto-incrementing pointer, a write that lands in an unimplemented slot, or a writable status byte makes the model and cfg_o disagree. Transfers are cut short by STOP and by repeated START, which exposes a design that commits a partial byte or misses the restart. The brownout sequence checks that a plain status read lowers the alert but keeps the flag, and that only the low-high-low control toggle followed by a read clears it.

// File: rtl/i2c_tgt_pkg.sv
// Shared definitions for the I2C register target.
// Assumes 8-bit registers and an 8-bit register pointer.
package i2c_tgt_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WR,
        ST_RD,
        ST_RACK
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the clock domain through two flops each and
// flags clock edges and START/STOP conditions. Assumes the bus idles high.
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] meta_q, sync_q, prev_q;  // bit 1 = SCL, bit 0 = SDA

    // Synchroniser chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 2'b11;
            sync_q <= 2'b11;
            prev_q <= 2'b11;
        end else begin
            meta_q <= {scl_i, sda_i};
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        sda_s     = sync_q[0];
        scl_rise  = sync_q[1] & ~prev_q[1];
        scl_fall  = ~sync_q[1] & prev_q[1];
        start_det = sync_q[1] & prev_q[1] & prev_q[0] & ~sync_q[0];
        stop_det  = sync_q[1] & prev_q[1] & ~prev_q[0] & sync_q[0];
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
// Byte-level bus engine: address match, ACK generation, pointer capture,
// write strobes and read shifting. The pointer never auto-increments and
// persists across transactions. Assumes inputs from i2c_line_sync.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] rdata,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_load,
    output logic [DATA_W-1:0] ptr
);
    tgt_state_e        state_q;
    logic [2:0]        cnt_q;
    logic [DATA_W-1:0] sh_q;
    logic              is_rd_q, first_wr_q, ack_drv_q, mack_q;

    // Main bus state machine; START/STOP override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            sh_q       <= '0;
            is_rd_q    <= 1'b0;
            first_wr_q <= 1'b0;
            ack_drv_q  <= 1'b0;
            mack_q     <= 1'b0;
            sda_oe     <= 1'b0;
            wr_en      <= 1'b0;
            wr_data    <= '0;
            rd_load    <= 1'b0;
            ptr        <= '0;
        end else begin
            wr_en   <= 1'b0;
            rd_load <= 1'b0;
            if (start_det) begin
                state_q    <= ST_ADDR;
                cnt_q      <= '0;
                sda_oe     <= 1'b0;
                ack_drv_q  <= 1'b0;
                first_wr_q <= 1'b1;
            end else if (stop_det) begin
                state_q   <= ST_IDLE;
                sda_oe    <= 1'b0;
                ack_drv_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR: if (scl_rise) begin
                        sh_q  <= {sh_q[6:0], sda_s};
                        cnt_q <= cnt_q + 3'd1;
                        if (cnt_q == 3'd7) begin
                            is_rd_q <= sda_s;
                            state_q <= (sh_q[6:0] == TGT_ADDR) ? ST_ACK : ST_IDLE;
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (!ack_drv_q) begin
                            sda_oe    <= 1'b1;
                            ack_drv_q <= 1'b1;
                        end else begin
                            ack_drv_q <= 1'b0;
                            cnt_q     <= '0;
                            if (is_rd_q) begin
                                sh_q    <= rdata;
                                sda_oe  <= ~rdata[7];
                                rd_load <= 1'b1;
                                state_q <= ST_RD;
                            end else begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_WR;
                            end
                        end
                    end
                    ST_WR: if (scl_rise) begin
                        sh_q  <= {sh_q[6:0], sda_s};
                        cnt_q <= cnt_q + 3'd1;
                        if (cnt_q == 3'd7) begin
                            state_q <= ST_ACK;
                            if (first_wr_q) begin
                                ptr        <= {sh_q[6:0], sda_s};
                                first_wr_q <= 1'b0;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_data <= {sh_q[6:0], sda_s};
                            end
                        end
                    end
                    ST_RD: if (scl_fall) begin
                        if (cnt_q == 3'd7) begin
                            sda_oe  <= 1'b0;
                            state_q <= ST_RACK;
                        end else begin
                            sh_q   <= {sh_q[6:0], 1'b0};
                            sda_oe <= ~sh_q[6];
                            cnt_q  <= cnt_q + 3'd1;
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mack_q <= ~sda_s;
                        if (scl_fall) begin
                            if (mack_q) begin
                                sh_q    <= rdata;
                                sda_oe  <= ~rdata[7];
                                rd_load <= 1'b1;
                                cnt_q   <= '0;
                                state_q <= ST_RD;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !start_det |=> !sda_oe && state_q == ST_IDLE); // R10
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe && state_q == ST_ADDR); // R10
    AST_WR_AFTER_POINTER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !first_wr_q && state_q == ST_ACK); // R2
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> !rd_load); // R9
endmodule

// File: rtl/i2c_tgt_regbank.sv
// Register bank: status at location 0, NUM_RW read/write registers after
// it, and the brownout flag with its alert-clearing protocol.
// Assumes write and read strobes are single-cycle pulses from the engine.
module i2c_tgt_regbank
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_RW = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_load,
    input  logic [DATA_W-1:0]        ptr,
    input  logic [6:0]               stat_i,
    input  logic                     brownout_i,
    output logic [DATA_W-1:0]        rdata,
    output logic                     stat_rd,
    output logic                     alert,
    output logic [NUM_RW*DATA_W-1:0] cfg
);
    logic [DATA_W-1:0] rw_q [NUM_RW];
    logic              bo_q, seen_hi_q, armed_q, ctl0_prev_q;
    logic              ctl0;

    assign ctl0    = rw_q[0][0];
    assign stat_rd = rd_load && (ptr == '0);

    // One write-enabled register per implemented location.
    for (genvar k = 0; k < NUM_RW; k++) begin : g_rw
        always_ff @(posedge clk) begin
            if (!rst_n)                                     rw_q[k] <= '0;
            else if (wr_en && ptr == DATA_W'(k + 1))        rw_q[k] <= wr_data;
        end
        assign cfg[k*DATA_W +: DATA_W] = rw_q[k];
    end

    // Read multiplexer; unimplemented locations read zero.
    always_comb begin
        rdata = '0;
        if (ptr == '0) rdata = {stat_i[6:4], bo_q, stat_i[3:0]};
        for (int k = 0; k < NUM_RW; k++)
            if (ptr == DATA_W'(k + 1)) rdata = rw_q[k];
    end

    // Brownout flag, alert and the low-high-low arming of the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bo_q        <= 1'b0;
            alert       <= 1'b0;
            seen_hi_q   <= 1'b0;
            armed_q     <= 1'b0;
            ctl0_prev_q <= 1'b0;
        end else begin
            ctl0_prev_q <= ctl0;
            if (ctl0 && !ctl0_prev_q) seen_hi_q <= 1'b1;
            if (!ctl0 && ctl0_prev_q && seen_hi_q) begin
                armed_q   <= 1'b1;
                seen_hi_q <= 1'b0;
            end
            if (stat_rd) begin
                alert <= 1'b0;
                if (armed_q) begin
                    bo_q    <= 1'b0;
                    armed_q <= 1'b0;
                end
            end
            if (brownout_i) begin
                bo_q  <= 1'b1;
                alert <= 1'b1;
            end
        end
    end

    AST_BO_SETS_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
        brownout_i |=> bo_q && alert); // R6
    AST_BO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bo_q && !stat_rd |=> bo_q); // R7
    AST_BO_CLEAR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bo_q) |-> $past(armed_q) && $past(stat_rd)); // R8
    AST_UNIMPL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (ptr == '0 || ptr > DATA_W'(NUM_RW)) |=> $stable(cfg)); // R5
endmodule

// File: rtl/i2c_reg_target.sv
// Top level of the I2C register target: synchroniser, bus engine and
// register bank. Slave-only, no clock stretching, SDA is open-drain via
// sda_oe_o. Assumes SCL is slow relative to clk (at least 8 clk per phase).
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h20,
    parameter int         NUM_RW   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe_o,
    input  logic [6:0]               stat_i,
    input  logic                     brownout_i,
    output logic                     stat_rd_o,
    output logic                     alert_o,
    output logic [NUM_RW*DATA_W-1:0] cfg_o
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en, rd_load;
    logic [DATA_W-1:0] wr_data, ptr, rdata;

    i2c_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_engine #(.TGT_ADDR(TGT_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rdata(rdata), .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_data(wr_data),
        .rd_load(rd_load), .ptr(ptr)
    );

    i2c_tgt_regbank #(.NUM_RW(NUM_RW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_load(rd_load), .ptr(ptr), .stat_i(stat_i),
        .brownout_i(brownout_i), .rdata(rdata), .stat_rd(stat_rd_o),
        .alert(alert_o), .cfg(cfg_o)
    );

    AST_STAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_o |=> !stat_rd_o); // R9
endmodule

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
    localparam int Q = 5;
    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [6:0] stat_i = 7'h55;
    logic brownout_i = 1'b0;
    logic sda_oe_o, stat_rd_o, alert_o;
    logic [23:0] cfg_o;
    wire  sda_bus = sda_m & ~sda_oe_o;
    int checks = 0, fails = 0, pulses = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2c_reg_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe_o), .stat_i(stat_i), .brownout_i(brownout_i),
        .stat_rd_o(stat_rd_o), .alert_o(alert_o), .cfg_o(cfg_o)
    );

    always @(posedge clk) if (rst_n && stat_rd_o) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw; repeat (Q) @(negedge clk); endtask
    task automatic send_bit(input logic b);
        sda_m = b; qw; scl_m = 1; qw; qw; scl_m = 0; qw;
    endtask
    task automatic recv_bit(output logic b);
        sda_m = 1; qw; scl_m = 1; qw; b = sda_bus; qw; scl_m = 0; qw;
    endtask
    task automatic i2c_start;
        sda_m = 1; qw; scl_m = 1; qw; sda_m = 0; qw; scl_m = 0; qw;
    endtask
    task automatic i2c_stop;
        sda_m = 0; qw; scl_m = 1; qw; sda_m = 1; qw; qw;
    endtask
    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask
    task automatic read_byte(input logic mack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(~mack);
    endtask
    task automatic reg_write(input logic [7:0] p, input logic [7:0] v, output logic [2:0] acks);
        i2c_start; send_byte(8'h40, acks[2]); send_byte(p, acks[1]); send_byte(v, acks[0]); i2c_stop;
    endtask
    task automatic set_ptr(input logic [7:0] p);
        logic a0, a1;
        i2c_start; send_byte(8'h40, a0); send_byte(p, a1); i2c_stop;
    endtask
    task automatic reg_read(output logic [7:0] v);
        logic a;
        i2c_start; send_byte(8'h41, a); read_byte(1'b0, v); i2c_stop;
    endtask

    function automatic logic [7:0] stat_exp(input logic bo);
        return {stat_i[6:4], bo, stat_i[3:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R10 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [2:0] acks;
        logic [7:0] rd, v;
        logic [23:0] cfg_m;
        int p0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 sda_oe", sda_oe_o, 0);
        chk("R11 alert", alert_o, 0);
        chk("R11 cfg", cfg_o, 0);
        reg_read(rd);
        chk("R11 pointer 0 reads status", rd, stat_exp(0));

        // R1 sweep every address with write bit
        for (int a = 0; a < 128; a++) begin
            i2c_start; send_byte({7'(a), 1'b0}, ack); i2c_stop;
            chk($sformatf("R1 addr %0h", a), ack, (a == 32));
        end

        // R4/R5 sweep locations 0..7
        cfg_m = '0;
        for (int p = 0; p < 8; p++) begin
            v = 8'(8'h5A ^ (p * 37));
            reg_write(8'(p), v, acks);
            chk($sformatf("R5 acks loc %0d", p), acks, 3'b111);
            if (p >= 1 && p <= 3) cfg_m[(p-1)*8 +: 8] = v;
            chk($sformatf("R4 cfg after loc %0d", p), cfg_o, cfg_m);
            reg_read(rd);
            chk($sformatf("R4 R5 readback loc %0d", p), rd,
                (p == 0) ? stat_exp(0) : (p <= 3) ? v : 8'h00);
        end

        // R2 multi-byte write, same location
        i2c_start; send_byte(8'h40, ack); send_byte(8'h02, ack);
        send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack); i2c_stop;
        cfg_m[15:8] = 8'h33;
        chk("R2 no increment", cfg_o, cfg_m);

        // R3 multi-byte read with stored pointer
        pulses = 0;
        i2c_start; send_byte(8'h41, ack);
        for (int i = 0; i < 3; i++) begin
            read_byte(i < 2, rd);
            chk($sformatf("R3 byte %0d", i), rd, 8'h33);
        end
        i2c_stop;
        chk("R9 no pulse for loc 2", pulses, 0);

        // R9 three status bytes give three pulses
        set_ptr(8'h00);
        pulses = 0;
        i2c_start; send_byte(8'h41, ack);
        for (int i = 0; i < 3; i++) begin
            read_byte(i < 2, rd);
            chk("R3 status repeat", rd, stat_exp(0));
        end
        i2c_stop;
        chk("R9 pulse count", pulses, 3);

        // R10 repeated START mid data byte
        i2c_start; send_byte(8'h40, ack); send_byte(8'h01, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        i2c_start; send_byte(8'h41, ack);
        chk("R10 restart addr ack", ack, 1);
        read_byte(1'b0, rd); i2c_stop;
        chk("R10 restart no write", rd, cfg_m[7:0]);
        // R10 STOP mid data byte
        i2c_start; send_byte(8'h40, ack); send_byte(8'h03, ack);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        i2c_stop;
        chk("R10 stop no write", cfg_o, cfg_m);
        chk("R10 sda released", sda_oe_o, 0);

        // R6-R8 brownout protocol
        set_ptr(8'h00);
        @(negedge clk); brownout_i = 1; @(negedge clk); brownout_i = 0;
        chk("R6 alert set", alert_o, 1);
        reg_read(rd);
        chk("R6 flag in status", rd, stat_exp(1));
        chk("R7 alert cleared", alert_o, 0);
        reg_read(rd);
        chk("R7 flag sticky", rd, stat_exp(1));
        p0 = 0;
        reg_write(8'h01, 8'h01, acks);
        reg_write(8'h01, 8'h00, acks);
        set_ptr(8'h00);
        reg_read(rd);
        chk("R8 clearing read shows flag", rd, stat_exp(1));
        reg_read(rd);
        chk("R8 flag cleared", rd, stat_exp(0));
        chk("R8 alert stays low", alert_o, p0[0]);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule